// File: doc/BRIEF.md
# Four-Cell Mismatch-Shaping Selector

This block is the final node of a shortened selection tree for a unit-element DAC with four cells. Each clock it receives a count from 0 to 4. It returns a four-bit enable vector with exactly that many bits set. The aim is to spread the mismatch error of the cells away from the signal band.

Three switching values describe the chosen vector:
- the pair difference of cells 1 and 2;
- the pair difference of cells 3 and 4;
- the half difference, which is cells 1 and 2 minus cells 3 and 4.

Each switching value is negated and drives its own loop filter. A loop filter is two cascaded bandpass resonators with the transfer −z⁻²/(1+z⁻²), held in saturating registers. The three filter outputs feed a priority-ordered threshold table. That table picks the next vector, so the cells whose use has drifted furthest are corrected first.

The enable vector is registered, which gives one clock of latency. The filters advance from the registered vector.

Top module: `esb_selector`

## Requirements
- R1: While `rst` is high at a rising edge, `sel_out` becomes 0000 and every filter register becomes zero at that edge. After reset, a count of 1 with all filters at zero selects cell 1.
- R2: At each edge, `sel_out` takes a vector whose number of set bits equals the `cnt_in` value sampled at that edge. Counts of 5, 6 and 7 are treated as 4. Bit 0 of `sel_out` drives cell 1 and bit 3 drives cell 4.
- R3: A count of 0 gives 0000. A count of 4 or above gives 1111, whatever the filter states.
- R4: For a count of 1, the first matching rule wins. In each rule a cell is named, and a count of 1 lights only that cell. "a in band" means −T1 ≤ a < T1.
  - H ≥ −T2 and A ≥ T1: cell 1.
  - H ≥ 0, A ≥ 0 and B in band: cell 1.
  - H < T2 and A < −T1: cell 2.
  - H ≥ 0, A < 0 and B in band: cell 2.
  - A in band and B ≥ T1: cell 3.
  - H < 0, A in band and B ≥ 0: cell 3.
  - A in band and B < −T1: cell 4.
  - H < 0, A in band and B < 0: cell 4.

  Here H, A and B are the outputs of the half, first-pair and second-pair filters.
- R5: For a count of 2, the rules are tried in this order:
  - H ≥ T2 lights cells 1 and 2.
  - H < −T2 lights cells 3 and 4.
  - Otherwise one cell is lit from each pair. Cell 1 is lit if A ≥ 0, else cell 2. Cell 3 is lit if B ≥ 0, else cell 4.
- R6: For a count of 3, the first matching rule wins. Each rule names the cell left dark.
  - A in band and B ≥ T1: cell 4.
  - H ≥ 0, A in band and B ≥ 0: cell 4.
  - A in band and B < −T1: cell 3.
  - H ≥ 0, A in band and B < 0: cell 3.
  - A ≥ T1: cell 2.
  - H < 0, A ≥ 0 and B in band: cell 2.
  - A < −T1: cell 1.
  - H < 0, A < 0 and B in band: cell 1.
- R7: When no rule applies for a count of 1, 2 or 3, the vector is respectively cell 1 only, cells 1–2, or cells 1–3.
- R8: The switching values are computed from the current `sel_out`:
  - first pair = c1 − c2;
  - second pair = c3 − c4;
  - half = (c1 + c2) − (c3 + c4).

  Each resonator keeps two states p and q. At each edge p takes −q − x and q takes the old p, where x is the resonator's input. The output of a resonator is q. The first stage's input is the negated switching value, and the second stage's input is the first stage's output.
- R9: Every filter register is REG_W bits signed and saturates to ±(2^(REG_W−1)−1), which is ±31 by default.
- R10: The thresholds T1 and T2 are parameters. The other parameters are REG_W and the number of resonator stages per loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 3 | Number of cells to enable |
| sel_out | output | 4 | Registered cell enables, bit 0 = cell 1 |

## Verification
A wrong filter register does not show up at once. It first appears as a different cell choice, a few clocks later, once a filter output crosses a threshold on the wrong side. The bench therefore runs a full cycle-accurate model of the three loops next to the design and compares every vector one clock after its count is presented. The first divergent choice is reported in the cycle it occurs. A set-bit count error, by contrast, is visible in the very next cycle, whatever the filter state.

// File: rtl/esb_pkg.sv
package esb_pkg;
  localparam int CELLS = 4;
  localparam int CNT_W = 3;
  localparam int SW_W  = 3;

  typedef logic [CELLS-1:0] cells_t;

  function automatic cells_t cells(input logic c1, input logic c2,
                                   input logic c3, input logic c4);
    return {c4, c3, c2, c1};
  endfunction

  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(CELLS)) ? CNT_W'(CELLS) : c;
  endfunction
endpackage

// File: rtl/esb_resonator.sv
module esb_resonator #(
  parameter int W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] drive,
  output logic signed [W-1:0] res_out
);
  localparam int LIM = (2 ** (W - 1)) - 1;
  localparam logic signed [W+1:0] HI = (W+2)'(LIM);
  localparam logic signed [W+1:0] LO = (W+2)'(-LIM);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] st_p, st_q, sat;
  logic signed [W+1:0] wide;

  assign wide = -$signed({{2{st_q[W-1]}}, st_q}) - $signed({{2{drive[W-1]}}, drive});

  always_comb begin
    if (wide > HI)      sat = W'(LIM);
    else if (wide < LO) sat = W'(-LIM);
    else                sat = wide[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_p <= '0;
      st_q <= '0;
    end else begin
      st_p <= sat;
      st_q <= st_p;
    end
  end

  assign res_out = st_q;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (st_p != MOST_NEG) && (st_q != MOST_NEG));
  assert_shift_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (st_q == $past(st_p)) || $past(rst));
endmodule

// File: rtl/esb_loop.sv
module esb_loop #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic signed [esb_pkg::SW_W-1:0] sw,
  output logic signed [W-1:0]           v_out
);
  localparam int EXT = W - esb_pkg::SW_W;

  logic signed [W-1:0] link [STAGES+1];

  assign link[0] = -$signed({{EXT{sw[esb_pkg::SW_W-1]}}, sw});

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    esb_resonator #(.W(W)) u_res (
      .clk     (clk),
      .rst     (rst),
      .drive   (link[g]),
      .res_out (link[g+1])
    );
  end

  assign v_out = link[STAGES];
endmodule

// File: rtl/esb_decide.sv
module esb_decide #(
  parameter int W  = 6,
  parameter int T1 = 8,
  parameter int T2 = 8
) (
  input  logic [esb_pkg::CNT_W-1:0] cnt,
  input  logic signed [W-1:0]       vh,
  input  logic signed [W-1:0]       va,
  input  logic signed [W-1:0]       vb,
  output esb_pkg::cells_t           pick
);
  import esb_pkg::*;

  localparam logic signed [W-1:0] P1 = W'(T1);
  localparam logic signed [W-1:0] N1 = W'(-T1);
  localparam logic signed [W-1:0] P2 = W'(T2);
  localparam logic signed [W-1:0] N2 = W'(-T2);

  logic [CNT_W-1:0] c;
  logic h_pos, a_pos, b_pos, a_band, b_band;

  assign c      = clamp_count(cnt);
  assign h_pos  = !vh[W-1];
  assign a_pos  = !va[W-1];
  assign b_pos  = !vb[W-1];
  assign a_band = (va >= N1) && (va < P1);
  assign b_band = (vb >= N1) && (vb < P1);

  always_comb begin
    pick = '0;
    case (c)
      3'd1: begin
        if (vh >= N2 && va >= P1)              pick = cells(1, 0, 0, 0);
        else if (h_pos && a_pos && b_band)     pick = cells(1, 0, 0, 0);
        else if (vh < P2 && va < N1)           pick = cells(0, 1, 0, 0);
        else if (h_pos && !a_pos && b_band)    pick = cells(0, 1, 0, 0);
        else if (a_band && vb >= P1)           pick = cells(0, 0, 1, 0);
        else if (!h_pos && a_band && b_pos)    pick = cells(0, 0, 1, 0);
        else if (a_band && vb < N1)            pick = cells(0, 0, 0, 1);
        else if (!h_pos && a_band && !b_pos)   pick = cells(0, 0, 0, 1);
        else                                   pick = cells(1, 0, 0, 0);
      end
      3'd2: begin
        if (vh >= P2)      pick = cells(1, 1, 0, 0);
        else if (vh < N2)  pick = cells(0, 0, 1, 1);
        else               pick = cells(a_pos, !a_pos, b_pos, !b_pos);
      end
      3'd3: begin
        if (a_band && vb >= P1)                pick = cells(1, 1, 1, 0);
        else if (h_pos && a_band && b_pos)     pick = cells(1, 1, 1, 0);
        else if (a_band && vb < N1)            pick = cells(1, 1, 0, 1);
        else if (h_pos && a_band && !b_pos)    pick = cells(1, 1, 0, 1);
        else if (va >= P1)                     pick = cells(1, 0, 1, 1);
        else if (!h_pos && a_pos && b_band)    pick = cells(1, 0, 1, 1);
        else if (va < N1)                      pick = cells(0, 1, 1, 1);
        else if (!h_pos && !a_pos && b_band)   pick = cells(0, 1, 1, 1);
        else                                   pick = cells(1, 1, 1, 0);
      end
      3'd4:    pick = cells(1, 1, 1, 1);
      default: pick = '0;
    endcase
  end
endmodule

// File: rtl/esb_selector.sv
module esb_selector #(
  parameter int REG_W  = 6,
  parameter int STAGES = 2,
  parameter int T1     = 8,
  parameter int T2     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cnt_in,
  output logic [3:0] sel_out
);
  import esb_pkg::*;

  localparam int NLOOP = 3;
  localparam logic signed [REG_W-1:0] P1 = REG_W'(T1);
  localparam logic signed [REG_W-1:0] N1 = REG_W'(-T1);
  localparam logic signed [REG_W-1:0] P2 = REG_W'(T2);
  localparam logic signed [REG_W-1:0] N2 = REG_W'(-T2);

  cells_t sel_q, nxt;
  logic signed [SW_W-1:0] c1, c2, c3, c4;
  logic signed [SW_W-1:0] sw [NLOOP];
  logic signed [REG_W-1:0] v [NLOOP];

  assign c1 = $signed({2'b00, sel_q[0]});
  assign c2 = $signed({2'b00, sel_q[1]});
  assign c3 = $signed({2'b00, sel_q[2]});
  assign c4 = $signed({2'b00, sel_q[3]});

  // loop 0: half difference, loop 1: first pair, loop 2: second pair
  assign sw[0] = (c1 + c2) - (c3 + c4);
  assign sw[1] = c1 - c2;
  assign sw[2] = c3 - c4;

  for (genvar k = 0; k < NLOOP; k++) begin : g_loop
    esb_loop #(.W(REG_W), .STAGES(STAGES)) u_loop (
      .clk   (clk),
      .rst   (rst),
      .sw    (sw[k]),
      .v_out (v[k])
    );
  end

  esb_decide #(.W(REG_W), .T1(T1), .T2(T2)) u_dec (
    .cnt  (cnt_in),
    .vh   (v[0]),
    .va   (v[1]),
    .vb   (v[2]),
    .pick (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= nxt;
  end

  assign sel_out = sel_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> sel_q == '0);
  assert_popcount_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(sel_q) == int'(clamp_count($past(cnt_in)))));
  assert_ends_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_in >= 3'd4) |=> (sel_q == 4'b1111));
  assert_single_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_in == 3'd1 && v[0] >= N2 && v[1] >= P1) |=> (sel_q == 4'b0001));
  assert_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_in == 3'd2 && v[0] >= P2) |=> (sel_q == 4'b0011));
  assert_pair_low_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_in == 3'd2 && v[0] < N2) |=> (sel_q == 4'b1100));
  assert_triple_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_in == 3'd3 && v[1] < N1) |=> (sel_q == 4'b1110));
endmodule

// File: tb/sim_esb_selector.sv
`timescale 1ns/1ps
module sim_esb_selector;
  localparam int W = 6;
  localparam int TH1 = 10;   // R10: non-default thresholds
  localparam int TH2 = 6;
  localparam int LIM = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cnt_in = '0;
  logic [3:0] sel_out;

  int total = 0;
  int bad = 0;
  logic [3:0] exp_q [$];
  int cnt_q [$];
  bit fb_q [$];

  // model state: index 0 half, 1 first pair, 2 second pair
  int p1 [3], q1 [3], p2 [3], q2 [3];
  logic [3:0] m_sel;

  always #2 clk = ~clk;

  esb_selector #(.REG_W(W), .STAGES(2), .T1(TH1), .T2(TH2)) u0 (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .sel_out(sel_out)
  );

  function automatic int sat(input int x);
    if (x > LIM) return LIM;
    if (x < -LIM) return -LIM;
    return x;
  endfunction

  function automatic logic [3:0] cv(input int a, input int b, input int c, input int d);
    logic [3:0] r;
    r[0] = (a != 0); r[1] = (b != 0); r[2] = (c != 0); r[3] = (d != 0);
    return r;
  endfunction

  function automatic logic [3:0] choose(input int n, input int h, input int a,
                                        input int b, output bit fb);
    bit ab, bb;
    ab = (a >= -TH1) && (a < TH1);
    bb = (b >= -TH1) && (b < TH1);
    fb = 0;
    if (n > 4) n = 4;
    if (n == 0) return 4'b0000;
    if (n == 4) return 4'b1111;
    if (n == 1) begin
      if (h >= -TH2 && a >= TH1) return cv(1,0,0,0);
      if (h >= 0 && a >= 0 && bb) return cv(1,0,0,0);
      if (h < TH2 && a < -TH1) return cv(0,1,0,0);
      if (h >= 0 && a < 0 && bb) return cv(0,1,0,0);
      if (ab && b >= TH1) return cv(0,0,1,0);
      if (h < 0 && ab && b >= 0) return cv(0,0,1,0);
      if (ab && b < -TH1) return cv(0,0,0,1);
      if (h < 0 && ab && b < 0) return cv(0,0,0,1);
      fb = 1; return cv(1,0,0,0);
    end
    if (n == 2) begin
      if (h >= TH2) return cv(1,1,0,0);
      if (h < -TH2) return cv(0,0,1,1);
      return cv(a >= 0, a < 0, b >= 0, b < 0);
    end
    if (ab && b >= TH1) return cv(1,1,1,0);
    if (h >= 0 && ab && b >= 0) return cv(1,1,1,0);
    if (ab && b < -TH1) return cv(1,1,0,1);
    if (h >= 0 && ab && b < 0) return cv(1,1,0,1);
    if (a >= TH1) return cv(1,0,1,1);
    if (h < 0 && a >= 0 && bb) return cv(1,0,1,1);
    if (a < -TH1) return cv(0,1,1,1);
    if (h < 0 && a < 0 && bb) return cv(0,1,1,1);
    fb = 1; return cv(1,1,1,0);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      p1[k] = 0; q1[k] = 0; p2[k] = 0; q2[k] = 0;
    end
    m_sel = '0;
  endtask

  task automatic model_step(input int n);
    int s [3];
    int np1, np2;
    bit fb;
    logic [3:0] nxt;
    nxt = choose(n, q2[0], q2[1], q2[2], fb);
    s[0] = (m_sel[0] + m_sel[1]) - (m_sel[2] + m_sel[3]);
    s[1] = m_sel[0] - m_sel[1];
    s[2] = m_sel[2] - m_sel[3];
    for (int k = 0; k < 3; k++) begin
      np1 = sat(-q1[k] + s[k]);
      np2 = sat(-q2[k] - q1[k]);
      q1[k] = p1[k]; p1[k] = np1;
      q2[k] = p2[k]; p2[k] = np2;
    end
    m_sel = nxt;
    exp_q.push_back(nxt);
    cnt_q.push_back(n);
    fb_q.push_back(fb);
  endtask

  task automatic drive(input int n);
    @(negedge clk);
    cnt_in = 3'(n);
    model_step(n);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    total++;
    if (sel_out !== 4'b0000) begin
      bad++;
      $display("FAIL R1 reset sel_out actual=%b expected=0000", sel_out);
    end
    rst = 1'b0;
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      int n, want;
      bit fb;
      string tag;
      e = exp_q.pop_front();
      n = cnt_q.pop_front();
      fb = fb_q.pop_front();
      want = (n > 4) ? 4 : n;
      case (want)
        0, 4: tag = "R3";
        1: tag = "R4";
        2: tag = "R5";
        default: tag = "R6";
      endcase
      if (fb) tag = {tag, " R7"};
      tag = {tag, " R8 R9 R10"};
      total++;
      if (sel_out !== e) begin
        bad++;
        $display("FAIL %s count=%0d sel_out actual=%b expected=%b", tag, n, sel_out, e);
      end
      total++;
      if ($countones(sel_out) != want) begin
        bad++;
        $display("FAIL R2 count=%0d set bits actual=%0d expected=%0d",
                 n, $countones(sel_out), want);
      end
    end
  end

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    do_reset();
    drive(1);                          // R1: zero filters pick cell 1
    drive(0); drive(4); drive(7); drive(5); drive(6);   // R3 clamp
    for (int i = 0; i < 40; i++) drive(1);
    for (int i = 0; i < 40; i++) drive(2);
    for (int i = 0; i < 40; i++) drive(3);
    for (int i = 0; i < 60; i++) drive((i % 2) ? 3 : 1);
    for (int i = 0; i < 50; i++) drive(i % 5);
    do_reset();
    drive(1);
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:5] == 3'd0) drive(int'(lfsr[2:0]));
      else drive(int'(lfsr[4:0]) % 5);
    end
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule